// File: doc/BRIEF.md
# Verified Configuration Stream Loader

This block takes a filter configuration delivered as a stream of 16-bit words and fills the filter engine's configuration memory with it. A load opens with one fixed identification word. Twelve data blocks of 42 words follow it, and each block ends with a 16-bit check word. The identification word and the check words are used only for validation and are never stored. Each block is collected in a small staging buffer. The block is copied into configuration memory only after its check word matches the CRC computed over it, so the memory only ever receives data that passed the check.

A strap input selects boot-from-ROM. When the strap is high as reset is released, the loader copies a built-in default configuration into the memory on its own, with no input stream. Three status outputs report progress: busy, a one-cycle done pulse and a sticky error flag. The filter engine reads the memory through its own port.

Top module: `cfg_loader`

## Requirements
- R1: After reset with `boot_rom` low, `busy`, `done`, `error` and `cfg_we` are all low.
- R2: While waiting, a load starts only on a valid word equal to 0x7725. `busy` goes high in the next cycle. Any other valid word while waiting is dropped, and it neither raises `busy` nor causes a write.
- R3: After the identification word, the loader takes 12 blocks of 42 valid data words, each block followed by one check word. A cycle with `in_valid` low is skipped. A load that completes leaves all 504 data words in configuration memory.
- R4: The check word of a block must equal CRC-16 over that block's 42 words. The CRC uses polynomial 0x1021 and initial value 0xFFFF, and runs bit 15 first through bit 0 of each word. It restarts for every block.
- R5: When a check word matches, the block's 42 words are written one per cycle on consecutive cycles, in arrival order. The writes start in the cycle after the check word. Identification words and check words are never written. Words presented during these write cycles are discarded.
- R6: When a check word does not match, `error` rises in the next cycle and `busy` falls in that same cycle. Nothing from that block is written, and the loader goes back to waiting for an identification word. `error` stays high until reset.
- R7: `done` is high for exactly one cycle, the cycle after the final write of a load. `busy` is high from the cycle after the load starts through its final write, and it is low while `done` is high.
- R8: When `boot_rom` is high at reset release, the loader writes address i with (i·0x9E37 mod 2^16) XOR 0x5A5A for i = 0 to 503. These writes run on consecutive cycles, starting in the first cycle after reset is released. Inputs are ignored until the `done` pulse that follows.
- R9: Block b word i is written to address b·42+i. No write goes to an address above 503.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_rom | input | 1 | Strap: load the built-in default configuration after reset |
| in_valid | input | 1 | `in_data` carries a stream word this cycle |
| in_data | input | 16 | Stream word |
| cfg_we | output | 1 | Configuration memory write enable |
| cfg_addr | output | 9 | Configuration memory word address |
| cfg_wdata | output | 16 | Configuration memory write data |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle pulse: a load has finished |
| error | output | 1 | Sticky: a check word did not match |

## Verification
Each result has a fixed latency. `busy` rises one cycle after the identification word is sampled. Word i of a verified block is written i+1 cycles after its check word is sampled. `error` rises one cycle after a bad check word. `done` comes one cycle after the final write. ROM writes begin at the first edge after reset release. The bench's behavioural model moves at each rising edge on the same sampled inputs. Every output is compared with the model at the following falling edge, half a cycle after the register edge that produced it. Inputs change only on falling edges, so the result does not depend on process order.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [2:0] {
    S_WAIT   = 3'd0,
    S_ROM    = 3'd1,
    S_DATA   = 3'd2,
    S_CHECK  = 3'd3,
    S_COMMIT = 3'd4,
    S_DONE   = 3'd5
  } ldr_state_e;

  // One 16-bit word through CRC-16 (poly 0x1021), bit 15 first.
  function automatic logic [15:0] crc16_word(input logic [15:0] crc_in,
                                             input logic [15:0] word);
    logic [15:0] c;
    c = crc_in;
    for (int k = 15; k >= 0; k--) begin
      if (c[15] ^ word[k]) c = {c[14:0], 1'b0} ^ 16'h1021;
      else                 c = {c[14:0], 1'b0};
    end
    return c;
  endfunction

  // Default configuration word, computed instead of stored.
  function automatic logic [15:0] rom_word(input logic [31:0] idx,
                                           input logic [15:0] mult,
                                           input logic [15:0] mask);
    logic [31:0] p;
    p = idx * {16'd0, mult};
    return p[15:0] ^ mask;
  endfunction

endpackage

// File: rtl/cfg_crc_acc.sv
module cfg_crc_acc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        en,
  input  logic [15:0] word,
  output logic [15:0] crc
);
  import cfg_loader_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc <= 16'hFFFF;
    else if (clear) crc <= 16'hFFFF;
    else if (en)    crc <= crc16_word(crc, word);
  end

endmodule

// File: rtl/cfg_stage_buf.sv
module cfg_stage_buf #(
  parameter int DEPTH = 42,
  parameter int WORD_W = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter logic [15:0] ID_WORD   = 16'h7725,
  parameter int          BLK_WORDS = 42,
  parameter int          NUM_BLKS  = 12,
  parameter logic [15:0] ROM_MULT  = 16'h9E37,
  parameter logic [15:0] ROM_MASK  = 16'h5A5A,
  localparam int CFG_WORDS = BLK_WORDS * NUM_BLKS,
  localparam int CFG_AW    = $clog2(CFG_WORDS),
  localparam int BLK_AW    = $clog2(BLK_WORDS),
  localparam int BLK_W     = $clog2(NUM_BLKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_rom,
  input  logic              in_valid,
  input  logic [15:0]       in_data,
  output logic              cfg_we,
  output logic [CFG_AW-1:0] cfg_addr,
  output logic [15:0]       cfg_wdata,
  output logic              busy,
  output logic              done,
  output logic              error
);
  import cfg_loader_pkg::*;

  ldr_state_e        state;
  logic [CFG_AW-1:0] cnt;
  logic [BLK_W-1:0]  blk;
  logic              first_q;
  logic              err_q;

  // Named internal events
  logic        rom_start, id_hit, data_take, chk_pass, chk_fail;
  logic        crc_clear;
  logic [15:0] crc_val, stage_rdata;
  logic        cnt_blk_end, cnt_rom_end, last_blk;

  assign rom_start   = (state == S_WAIT) && first_q && boot_rom;
  assign id_hit      = (state == S_WAIT) && !rom_start && in_valid && (in_data == ID_WORD);
  assign data_take   = (state == S_DATA) && in_valid;
  assign chk_pass    = (state == S_CHECK) && in_valid && (in_data == crc_val);
  assign chk_fail    = (state == S_CHECK) && in_valid && (in_data != crc_val);
  assign crc_clear   = (state == S_WAIT) || (state == S_COMMIT);
  assign cnt_blk_end = (cnt == CFG_AW'(BLK_WORDS - 1));
  assign cnt_rom_end = (cnt == CFG_AW'(CFG_WORDS - 1));
  assign last_blk    = (blk == BLK_W'(NUM_BLKS - 1));

  cfg_crc_acc u_crc (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(crc_clear),
    .en   (data_take),
    .word (in_data),
    .crc  (crc_val)
  );

  cfg_stage_buf #(.DEPTH(BLK_WORDS), .WORD_W(16)) u_stage (
    .clk  (clk),
    .we   (data_take),
    .waddr(cnt[BLK_AW-1:0]),
    .wdata(in_data),
    .raddr(cnt[BLK_AW-1:0]),
    .rdata(stage_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_WAIT;
      cnt     <= '0;
      blk     <= '0;
      first_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      first_q <= 1'b0;
      unique case (state)
        S_WAIT: begin
          if (rom_start) begin
            state <= S_ROM;
            cnt   <= '0;
          end else if (id_hit) begin
            state <= S_DATA;
            cnt   <= '0;
            blk   <= '0;
          end
        end
        S_ROM: begin
          if (cnt_rom_end) state <= S_DONE;
          else             cnt   <= cnt + 1'b1;
        end
        S_DATA: begin
          if (data_take) begin
            if (cnt_blk_end) begin
              state <= S_CHECK;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        S_CHECK: begin
          if (chk_pass) begin
            state <= S_COMMIT;
          end else if (chk_fail) begin
            state <= S_WAIT;
            err_q <= 1'b1;
          end
        end
        S_COMMIT: begin
          if (cnt_blk_end) begin
            cnt <= '0;
            if (last_blk) begin
              state <= S_DONE;
            end else begin
              blk   <= blk + 1'b1;
              state <= S_DATA;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DONE:  state <= S_WAIT;
        default: state <= S_WAIT;
      endcase
    end
  end

  assign cfg_we    = (state == S_ROM) || (state == S_COMMIT);
  assign cfg_addr  = (state == S_ROM) ? cnt
                   : (CFG_AW'(blk) * CFG_AW'(BLK_WORDS) + cnt);
  assign cfg_wdata = (state == S_ROM) ? rom_word({{(32-CFG_AW){1'b0}}, cnt}, ROM_MULT, ROM_MASK)
                   : stage_rdata;
  assign busy      = (state == S_ROM) || (state == S_DATA) ||
                     (state == S_CHECK) || (state == S_COMMIT);
  assign done      = (state == S_DONE);
  assign error     = err_q;

  // Assertions
  assert_write_in_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> busy);

  assert_busy_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy)) |-> ($past(id_hit) || $past(rom_start)));

  assert_addr_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> (cfg_addr < CFG_AW'(CFG_WORDS)));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && $past(cfg_we)) |-> (cfg_addr == $past(cfg_addr) + 1'b1));

  assert_fail_reaction_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_fail |=> (error && !busy && !cfg_we));

  assert_error_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(cfg_we) && !busy));

endmodule

// File: tb/test_cfg_loader.sv
module test_cfg_loader;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_rom = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        cfg_we;
  logic [8:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        busy, done, error;

  cfg_loader i_cfg_loader (
    .clk(clk), .rst_n(rst_n), .boot_rom(boot_rom),
    .in_valid(in_valid), .in_data(in_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .busy(busy), .done(done), .error(error)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Independent restatements: bytewise CRC, integer ROM formula
  function automatic int ref_crc(input int crc, input int w);
    int c;
    c = crc;
    for (int by = 1; by >= 0; by--) begin
      c = c ^ (((w >> (8 * by)) & 255) << 8);
      for (int b = 0; b < 8; b++)
        c = ((c & 32768) != 0) ? (((c << 1) ^ 4129) & 65535) : ((c << 1) & 65535);
    end
    return c;
  endfunction

  function automatic int ref_rom(input int i);
    return ((i * 40503) & 65535) ^ 23130;
  endfunction

  // Behavioural reference model
  int mode = 0;          // 0 wait,1 rom,2 data,3 check,4 commit,5 done
  int m_ptr = 0, m_blk = 0, m_crc = 65535;
  bit m_first = 1, m_err = 0;
  int sq[$];

  int exp_mem [504];
  int dut_mem [504];
  int done_cnt = 0, wr_cnt = 0, max_addr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mode = 0; m_ptr = 0; m_blk = 0; m_first = 1; m_err = 0;
      m_crc = 65535; sq.delete();
    end else begin
      case (mode)
        0: if (m_first && boot_rom) begin mode = 1; m_ptr = 0; end
           else if (in_valid && in_data == 16'h7725) begin
             mode = 2; m_blk = 0; m_crc = 65535; sq.delete();
           end
        1: if (m_ptr == 503) mode = 5; else m_ptr++;
        2: if (in_valid) begin
             sq.push_back(int'(in_data));
             m_crc = ref_crc(m_crc, int'(in_data));
             if (sq.size() == 42) mode = 3;
           end
        3: if (in_valid) begin
             if (int'(in_data) == m_crc) begin mode = 4; m_ptr = 0; end
             else begin m_err = 1; mode = 0; end
           end
        4: begin
             void'(sq.pop_front());
             m_ptr++;
             if (sq.size() == 0) begin
               if (m_blk == 11) mode = 5;
               else begin m_blk++; mode = 2; m_crc = 65535; end
             end
           end
        default: mode = 0;
      endcase
      m_first = 0;
    end
  end

  // Per-cycle comparison, half a cycle after each register edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int ea, ed;
      bit ewe;
      ewe = (mode == 1) || (mode == 4);
      chk("R7 busy", int'(busy), int'(mode >= 1 && mode <= 4));
      chk("R7 done", int'(done), int'(mode == 5));
      chk("R6 error", int'(error), int'(m_err));
      chk("R5 write enable", int'(cfg_we), int'(ewe));
      if (ewe) begin
        ea = (mode == 1) ? m_ptr : m_blk * 42 + m_ptr;
        ed = (mode == 1) ? ref_rom(m_ptr) : sq[0];
        chk("R9 address", int'(cfg_addr), ea);
        chk("R5 data", int'(cfg_wdata), ed);
        exp_mem[ea] = ed;
      end
      if (cfg_we) begin
        wr_cnt++;
        if (int'(cfg_addr) < 504) dut_mem[cfg_addr] = int'(cfg_wdata);
        if (int'(cfg_addr) > max_addr) max_addr = int'(cfg_addr);
      end
      if (done) done_cnt++;
    end
  end

  task automatic put(input logic [15:0] w);
    in_valid = 1'b1;
    in_data  = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] pat(input int seed, input int b, input int i);
    if (b == 1 && i == 0) return 16'h7725;   // identification value inside data
    return 16'((seed * 7919 + b * 997 + i * 131 + 17) & 65535);
  endfunction

  task automatic send_stream(input int seed, input int bad_blk, input bit gaps);
    int c;
    put(16'h7725);
    for (int b = 0; b < 12; b++) begin
      c = 65535;
      for (int i = 0; i < 42; i++) begin
        if (gaps && (i % 9 == 4)) idle(1);
        put(pat(seed, b, i));
        c = ref_crc(c, int'(pat(seed, b, i)));
      end
      put((b == bad_blk) ? 16'(c ^ 1) : 16'(c));
      if (b == bad_blk) return;
      if (b == 0) begin idle(5); put(16'hDEAD); idle(40); end  // dropped word, R5
      else idle(44);
    end
  endtask

  function automatic int mem_mismatch();
    int n = 0;
    for (int i = 0; i < 504; i++) if (dut_mem[i] != exp_mem[i]) n++;
    return n;
  endfunction

  initial begin
    for (int i = 0; i < 504; i++) begin exp_mem[i] = 0; dut_mem[i] = 0; end
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 error", int'(error), 0);
    chk("R1 cfg_we", int'(cfg_we), 0);

    // R2: wrong identification words are dropped
    put(16'h7724); put(16'h2577); put(16'h0000);
    idle(2);
    chk("R2 busy after wrong id", int'(busy), 0);
    chk("R2 writes after wrong id", wr_cnt, 0);

    // R3/R4/R5: full load with gaps and a word during commit
    send_stream(1, -1, 1);
    idle(3);
    chk("R3 memory after load", mem_mismatch(), 0);
    chk("R3 write count", wr_cnt, 504);
    chk("R4 no error on good check words", int'(error), 0);
    chk("R7 done pulses", done_cnt, 1);

    // R6: bad check word in block 3
    send_stream(2, 3, 0);
    idle(3);
    chk("R6 error set", int'(error), 1);
    chk("R6 busy dropped", int'(busy), 0);
    chk("R6 only three blocks written", wr_cnt, 504 + 126);
    chk("R6 memory after abort", mem_mismatch(), 0);
    chk("R6 no done on abort", done_cnt, 1);

    // R6 sticky across a later good load
    send_stream(3, -1, 0);
    idle(3);
    chk("R6 error still set", int'(error), 1);
    chk("R3 memory after reload", mem_mismatch(), 0);
    chk("R7 done pulses after reload", done_cnt, 2);

    // R8: boot from ROM, inputs ignored meanwhile
    boot_rom = 1'b1;
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(10);
    put(16'h7725); put(16'h1234);
    idle(500);
    boot_rom = 1'b0;
    begin
      int n = 0;
      for (int i = 0; i < 504; i++) if (dut_mem[i] != ref_rom(i)) n++;
      chk("R8 ROM contents", n, 0);
    end
    chk("R8 error cleared by reset", int'(error), 0);
    chk("R8 done after ROM load", done_cnt, 3);
    chk("R9 highest address", max_addr, 503);
    chk("R8 idle after ROM load", int'(busy), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule